// File: doc/BRIEF.md
# JTAG Data Register to Register Port Bridge

This block is a 32-bit JTAG data register that gives a JTAG host read and write access to a 16-bit register port. The register port runs on its own clock, `dclk`, which has no fixed relation to `tck`. The TAP controller is outside the block. It supplies one-cycle Capture, Shift and Update indications in the `tck` domain.

The host shifts a command word in on `tdi`, least-significant bit first. At the same time, the word captured at the start of that scan shifts out on `tdo`. On Update, the command is latched and a toggle flag passes it to a `dclk`-side arbiter. The arbiter raises the port enable for one cycle, waits for the port's ready strobe, and keeps any read data in a result register. The next scan's Capture loads that result into the low half of the data register. A read therefore takes two scans. Scans can be chained, so each scan returns the result of the command before it while carrying the next command in.

The host should leave at least ten Run-Test-Idle cycles after an Update so the access can finish. If the host captures earlier, it gets the old result.

Top module: `jtag_regport_bridge`

## Requirements
- R1: The data register is 32 bits wide. While `shift_dr` is high, each `tck` rising edge moves it one place toward bit 0 and loads `tdi` into bit 31. `tdo` always shows bit 0, so a scanned-out word leaves least-significant bit first.
- R2: On `capture_dr`, the data register loads the arbiter's stored 16-bit result into bits [15:0] and zero into bits [31:16].
- R3: On `update_dr`, when no command is outstanding, the data register is latched as the command. Its fields are: opcode in bits [29:26], register address in bits [25:16], data in bits [15:0].
- R4: Opcode 4'b0001 is a read. The arbiter drives `rp_en` high for exactly one `dclk` cycle with `rp_we` low and the command's address. It then waits for `rp_ready` and stores `rp_rdata` as the new result. A following scan returns that result.
- R5: Opcode 4'b0010 is a write. It drives `rp_en` with `rp_we` high and the command's data on `rp_wdata`. It leaves the stored result unchanged.
- R6: Any other opcode, including 4'b0000, is a no-op. It starts no port access and leaves the stored result unchanged.
- R7: A Capture that happens before an outstanding read has finished returns the previously stored result.
- R8: An Update that arrives while the previous command is still outstanding is dropped. The held command does not change.
- R9: Reset (`trst` and `drst`, both synchronous) clears the stored result to zero and returns the arbiter to idle, so the first capture reads zero.
- R10: Command bits [31:30] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst | input | 1 | Synchronous reset, tck domain |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of data register) |
| capture_dr | input | 1 | TAP in Capture-DR for this register |
| shift_dr | input | 1 | TAP in Shift-DR for this register |
| update_dr | input | 1 | TAP in Update-DR for this register |
| dclk | input | 1 | Register port clock |
| drst | input | 1 | Synchronous reset, dclk domain |
| rp_en | output | 1 | One-cycle access strobe |
| rp_we | output | 1 | Access is a write |
| rp_addr | output | 10 | Register address |
| rp_wdata | output | 16 | Write data |
| rp_rdata | input | 16 | Read data, valid with rp_ready |
| rp_ready | input | 1 | Access complete strobe |

## Verification
The hardest cases to reach are the races between the two clocks: a Capture that arrives while a read is still in flight, and an Update that arrives while a command is still outstanding. To create them, the bench's register model is given a very long ready latency. A slow read is followed immediately by a scan with no idle cycles. That scan must return the stale result, and its write command must be dropped. Later scans with normal latency then show that the slow read's data finally arrives and that the dropped write never reached the register.

// File: rtl/jtag_regport_bridge.sv
module jtag_regport_bridge #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int SW = 32
) (
  input  logic          tck,
  input  logic          trst,
  input  logic          tdi,
  output logic          tdo,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          dclk,
  input  logic          drst,
  output logic          rp_en,
  output logic          rp_we,
  output logic [AW-1:0] rp_addr,
  output logic [DW-1:0] rp_wdata,
  input  logic [DW-1:0] rp_rdata,
  input  logic          rp_ready
);
  localparam int OPL = DW + AW;
  localparam int CW  = OPL + 4;
  localparam logic [3:0] OP_RD = 4'b0001;
  localparam logic [3:0] OP_WR = 4'b0010;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} st_t;

  logic [SW-1:0] sr;
  logic [CW-1:0] cmd_q;
  logic          req_t, ack_s1, ack_s2;
  logic          req_s1, req_s2, req_s3, ack_t;
  logic [DW-1:0] hold;
  st_t           st;
  logic [3:0]    op;
  logic          pending, new_req;

  assign tdo     = sr[0];
  assign pending = req_t ^ ack_s2;
  assign new_req = req_s2 ^ req_s3;
  assign op      = cmd_q[OPL +: 4];
  assign rp_en   = (st == ISSUE);
  assign rp_we   = (op == OP_WR);
  assign rp_addr = cmd_q[DW +: AW];
  assign rp_wdata = cmd_q[DW-1:0];

  always_ff @(posedge tck) begin
    if (trst) begin
      sr <= '0; cmd_q <= '0; req_t <= 1'b0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      if (capture_dr)    sr <= {{(SW-DW){1'b0}}, hold};
      else if (shift_dr) sr <= {tdi, sr[SW-1:1]};
      if (update_dr && !pending) begin
        cmd_q <= sr[CW-1:0];
        req_t <= ~req_t;
      end
    end
  end

  always_ff @(posedge dclk) begin
    if (drst) begin
      req_s1 <= 1'b0; req_s2 <= 1'b0; req_s3 <= 1'b0;
      ack_t <= 1'b0; hold <= '0; st <= IDLE;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      case (st)
        IDLE:
          if (new_req) begin
            if (op == OP_RD || op == OP_WR) st <= ISSUE;
            else ack_t <= ~ack_t;
          end
        ISSUE: st <= WAIT;
        default:
          if (rp_ready) begin
            if (op == OP_RD) hold <= rp_rdata;
            ack_t <= ~ack_t;
            st <= IDLE;
          end
      endcase
    end
  end

  a_r4_en_one_cycle: assert property (@(posedge dclk) disable iff (drst)
    rp_en |=> !rp_en);

  a_r5_hold_only_on_read: assert property (@(posedge dclk) disable iff (drst)
    (!$stable(hold) && !$past(drst)) |-> $past(st == WAIT && rp_ready && !rp_we));

  a_r8_cmd_held: assert property (@(posedge tck) disable iff (trst)
    (update_dr && pending) |=> $stable(cmd_q));

  a_r2_upper_zero: assert property (@(posedge tck) disable iff (trst)
    (capture_dr && !shift_dr) |=> (sr[SW-1:DW] == '0));
endmodule

// File: tb/sim_jtag_regport_bridge.sv
module sim_jtag_regport_bridge;
  logic tck = 0, dclk = 0, trst = 1, drst = 1;
  logic tdi = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic tdo, rp_en, rp_we, rp_ready = 0;
  logic [9:0] rp_addr;
  logic [15:0] rp_wdata, rp_rdata = 0;

  int checks = 0, fails = 0, lat = 3, acc = 0;
  logic [31:0] exp_q[$], got_q[$];
  string tag_q[$];
  logic [15:0] mem [1024];

  always #2 dclk = ~dclk;
  always #20 tck = ~tck;

  jtag_regport_bridge u0 (.tck(tck), .trst(trst), .tdi(tdi), .tdo(tdo),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .dclk(dclk), .drst(drst), .rp_en(rp_en), .rp_we(rp_we), .rp_addr(rp_addr),
    .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .rp_ready(rp_ready));

  function automatic logic [15:0] init(input int a);
    return 16'h5A00 ^ 16'(a * 37);
  endfunction

  int cnt = -1;
  logic [9:0] a_l; logic we_l; logic [15:0] d_l;
  always @(posedge dclk) begin
    rp_ready <= 1'b0;
    if (rp_en) begin
      cnt <= lat; a_l <= rp_addr; we_l <= rp_we; d_l <= rp_wdata; acc <= acc + 1;
    end else if (cnt == 0) begin
      rp_ready <= 1'b1;
      rp_rdata <= mem[a_l];
      if (we_l) mem[a_l] <= d_l;
      cnt <= -1;
    end else if (cnt > 0) cnt <= cnt - 1;
  end

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", t, got, exp);
    end
  endtask

  task automatic scan(input logic [31:0] cmd, input logic [31:0] exp, input string t, input int idle);
    logic [31:0] o;
    exp_q.push_back(exp); tag_q.push_back(t);
    @(negedge tck) capture_dr = 1;
    @(negedge tck) capture_dr = 0;
    shift_dr = 1;
    for (int i = 0; i < 32; i++) begin
      tdi = cmd[i]; o[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge tck) update_dr = 0;
    got_q.push_back(o);
    repeat (idle) @(negedge tck);
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input int a, input logic [15:0] d);
    return {2'b00, op, 10'(a), d};
  endfunction

  initial forever begin
    wait (got_q.size() > 0);
    check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    for (int i = 0; i < 1024; i++) mem[i] = init(i);
    repeat (3) @(negedge tck);
    trst = 0; drst = 0;
    scan(mk(4'b0010, 5, 16'hBEEF), 32'h0, "R9 reset result zero, R1", 12);
    scan(mk(4'b0001, 7, 16'h0), 32'h0, "R5 write keeps result", 12);
    check("R5 write reached register", {16'h0, mem[5]}, 32'h0000BEEF);
    c0 = acc;
    scan(mk(4'b0000, 3, 16'h1234), {16'h0, init(7)}, "R4 read result, R2 upper zero", 12);
    check("R6 no-op starts no access", acc, c0);
    scan(mk(4'b1111, 5, 16'h0), {16'h0, init(7)}, "R6 no-op keeps result", 12);
    check("R6 undefined opcode starts no access", acc, c0);
    scan({2'b11, 4'b0001, 10'd5, 16'hFFFF}, {16'h0, init(7)}, "R6 result after undefined op", 12);
    scan(mk(4'b0000, 0, 16'h0), 32'h0000BEEF, "R10 reserved bits ignored, R3", 12);
    lat = 500;
    scan(mk(4'b0001, 9, 16'h0), 32'h0000BEEF, "R3 read issued", 0);
    scan(mk(4'b0010, 9, 16'h1111), 32'h0000BEEF, "R7 stale capture", 80);
    lat = 3;
    scan(mk(4'b0000, 0, 16'h0), {16'h0, init(9)}, "R7 slow read arrives", 12);
    check("R8 dropped write not applied", {16'h0, mem[9]}, {16'h0, init(9)});
    scan(mk(4'b0001, 9, 16'h0), {16'h0, init(9)}, "R4 hold stable", 12);
    scan(mk(4'b0000, 0, 16'h0), {16'h0, init(9)}, "R8 dropped write", 12);
    @(negedge tck) begin trst = 1; drst = 1; end
    repeat (2) @(negedge tck);
    trst = 0; drst = 0;
    scan(mk(4'b0000, 0, 16'h0), 32'h0, "R9 reset clears result", 12);
    wait (got_q.size() == 0);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule